// File: doc/BRIEF.md
# Per-Peripheral Clock Rate Selector

This block keeps one byte of clock-rate configuration on a byte-wide special-function-register bus. From it, the block produces single-cycle clock-enable strobes for the CPU machine cycle and for six peripheral domains: watchdog, counter array, serial port, timer 2, timer 1 and timer 0. Bit 0 of the byte sets the global speed. When it is clear, a cycle lasts 12 oscillator clocks. When it is set, a cycle lasts 6 oscillator clocks.

In double-speed mode, each peripheral has its own bit that holds it at the standard 12-clock rate while the CPU runs at 6. When the global bit is clear, the peripheral bits have no effect. All strobes come from one free-running divide-by-12 counter, so the 6-clock and 12-clock rates stay phase-aligned. A new register value takes effect only at the next wrap of that counter, so changing the rate never produces a short or stretched strobe interval.

Top module: `clk_rate_sel`

## Requirements
- R1: After reset the register reads 0x00, and the CPU and all six peripheral strobes repeat every 12 clocks.
- R2: A write with `sfr_wr` high and `sfr_addr` equal to 0x8F loads `sfr_wdata` into the register. A read with `sfr_rd` high at 0x8F returns the register value on `sfr_rdata`.
- R3: Bit 7 of the register always reads as 0, whatever value was written to it.
- R4: A write to any address other than 0x8F leaves the register and every strobe rate unchanged. A read of any other address returns 0x00.
- R5: While bit 0 is clear, `cpu_tick` and every bit of `per_tick` repeat every 12 clocks, whatever bits 6 to 1 hold.
- R6: While bit 0 is set, `cpu_tick` repeats every 6 clocks.
- R7: While bit 0 is set, `per_tick[k]` is controlled by register bit k+1. Bit k+1 clear gives a period of 6 clocks and bit k+1 set gives 12. The mapping is: bit 6 watchdog (`per_tick[5]`), bit 5 counter array, bit 4 serial port, bit 3 timer 2, bit 2 timer 1, bit 1 timer 0 (`per_tick[0]`).
- R8: Each strobe is high for exactly one clock. The gap between two strobes on any output is always exactly 6 or 12 clocks, including across a rate change.
- R9: A register change takes effect only at the next wrap of the divide-by-12 counter. Every 12-clock strobe coincides with a strobe on all seven outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_addr | input | 8 | Special-function-register address |
| sfr_wr | input | 1 | Write strobe, one clock |
| sfr_rd | input | 1 | Read enable |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data; 0x00 unless reading 0x8F |
| cpu_tick | output | 1 | Machine-cycle enable strobe |
| per_tick | output | 6 | Peripheral strobes: [5] watchdog, [4] counter array, [3] serial port, [2] timer 2, [1] timer 1, [0] timer 0 |

## Verification
The interval and single-pulse assertions assume that the clock runs continuously and that reset is released only through the internal synchronizer. Under those conditions the divide-by-12 counter cannot skip a count. The register assertions assume `sfr_wr` is a clean one-clock pulse with a stable address. The stimulus drives every bus input on the falling clock edge and holds each write for exactly one cycle. It rewrites the register at arbitrary counter phases so that the wrap-boundary rule is tested across rate changes. Strobe counts are measured only after a settle time longer than one counter period plus the strobe pipeline.

// File: rtl/clk_rate_pkg.sv
package clk_rate_pkg;
  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned N_PERIPH = 6;
  localparam int unsigned N_OUT    = N_PERIPH + 1;
  localparam int unsigned DIV_SLOW = 12;
  localparam int unsigned DIV_FAST = 6;
  localparam int unsigned CNT_W    = $clog2(DIV_SLOW);
  localparam int unsigned GAP_W    = CNT_W + 1;
  localparam logic [ADDR_W-1:0] CFG_ADDR = 8'h8F;
  localparam logic [DATA_W-1:0] CFG_MASK = 8'h7F;
endpackage

// File: rtl/clk_rate_rstsync.sv
module clk_rate_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/clk_rate_regs.sv
module clk_rate_regs
  import clk_rate_pkg::*;
#(
  parameter int unsigned           AW    = ADDR_W,
  parameter int unsigned           DW    = DATA_W,
  parameter int unsigned           NO    = N_OUT,
  parameter logic [ADDR_W-1:0]     ADDR  = CFG_ADDR,
  parameter logic [DATA_W-1:0]     MASK  = CFG_MASK
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic          rd,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [NO-1:0] cfg
);
  logic [DW-1:0] cfg_q, cfg_d;
  logic          hit;

  assign hit = (addr == ADDR);

  always_comb begin
    cfg_d = cfg_q;
    if (wr && hit) cfg_d = wdata & MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  always_comb begin
    rdata = '0;
    if (rd && hit) rdata = cfg_q;
  end

  assign cfg = cfg_q[NO-1:0];

  // R2: an addressed write lands in the register
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit) |=> (cfg_q == ($past(wdata) & MASK)));
  // R4: a write elsewhere leaves the register alone
  a_r4_miss_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !hit) |=> $stable(cfg_q));
  // R3: the reserved top bit never reads back as one
  a_r3_top_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DW-1] == 1'b0);
endmodule

// File: rtl/clk_rate_phase.sv
module clk_rate_phase
  import clk_rate_pkg::*;
#(
  parameter int unsigned SLOW = DIV_SLOW,
  parameter int unsigned FAST = DIV_FAST,
  parameter int unsigned CW   = CNT_W
) (
  input  logic clk,
  input  logic rst_n,
  output logic wrap,
  output logic tick_slow,
  output logic tick_fast
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          slow_q, slow_d, fast_q, fast_d;

  assign wrap = (cnt_q == CW'(SLOW - 1));

  always_comb begin
    cnt_d  = wrap ? '0 : cnt_q + 1'b1;
    slow_d = (cnt_q == '0);
    fast_d = (cnt_q == CW'(FAST));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      slow_q <= 1'b0;
      fast_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      slow_q <= slow_d;
      fast_q <= fast_d;
    end
  end

  assign tick_slow = slow_q;
  assign tick_fast = fast_q;

  // R9: the phase counter stays in range
  a_r9_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(SLOW));
  // R9: mid-period and period-start strobes never overlap
  a_r9_phase_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    !(slow_q && fast_q));
endmodule

// File: rtl/clk_rate_strobe.sv
module clk_rate_strobe
  import clk_rate_pkg::*;
#(
  parameter int unsigned SLOW = DIV_SLOW,
  parameter int unsigned FAST = DIV_FAST,
  parameter int unsigned GW   = GAP_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap,
  input  logic tick_slow,
  input  logic tick_fast,
  input  logic sel_double,
  input  logic sel_hold,
  output logic strobe
);
  logic act_double_q, act_hold_q;
  logic act_double_d, act_hold_d;
  logic fast_mode;
  logic strobe_q, strobe_d;

  always_comb begin
    act_double_d = act_double_q;
    act_hold_d   = act_hold_q;
    if (wrap) begin
      act_double_d = sel_double;
      act_hold_d   = sel_hold;
    end
  end

  assign fast_mode = act_double_q && !act_hold_q;

  always_comb strobe_d = tick_slow || (fast_mode && tick_fast);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_double_q <= 1'b0;
      act_hold_q   <= 1'b0;
      strobe_q     <= 1'b0;
    end else begin
      act_double_q <= act_double_d;
      act_hold_q   <= act_hold_d;
      strobe_q     <= strobe_d;
    end
  end

  assign strobe = strobe_q;

  // interval tracker used only by the checks below
  logic [GW-1:0] gap_q;
  logic          seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (strobe_q) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q != '1) begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  // R8: strobe lasts one clock
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q |=> !strobe_q);
  // R8: strobe spacing is always one of the two legal periods
  a_r8_legal_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_q && seen_q) |-> (gap_q == GW'(FAST - 1) || gap_q == GW'(SLOW - 1)));
endmodule

// File: rtl/clk_rate_sel.sv
module clk_rate_sel
  import clk_rate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic              sfr_wr,
  input  logic              sfr_rd,
  input  logic [DATA_W-1:0] sfr_wdata,
  output logic [DATA_W-1:0] sfr_rdata,
  output logic              cpu_tick,
  output logic [N_PERIPH-1:0] per_tick
);
  logic             rst_n_s;
  logic [N_OUT-1:0] cfg;
  logic [N_OUT-1:0] ticks;
  logic             wrap, tick_slow, tick_fast;

  clk_rate_rstsync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  clk_rate_regs u_regs (
    .clk(clk), .rst_n(rst_n_s), .addr(sfr_addr), .wr(sfr_wr), .rd(sfr_rd),
    .wdata(sfr_wdata), .rdata(sfr_rdata), .cfg(cfg)
  );

  clk_rate_phase u_phase (
    .clk(clk), .rst_n(rst_n_s), .wrap(wrap),
    .tick_slow(tick_slow), .tick_fast(tick_fast)
  );

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    logic hold_bit;
    if (k == 0) begin : g_cpu
      assign hold_bit = 1'b0;
    end else begin : g_per
      assign hold_bit = cfg[k];
    end
    clk_rate_strobe u_strobe (
      .clk(clk), .rst_n(rst_n_s), .wrap(wrap),
      .tick_slow(tick_slow), .tick_fast(tick_fast),
      .sel_double(cfg[0]), .sel_hold(hold_bit), .strobe(ticks[k])
    );
  end

  assign cpu_tick = ticks[0];
  assign per_tick = ticks[N_OUT-1:1];

  // R9: every period-start strobe reaches all outputs together
  a_r9_common_phase: assert property (@(posedge clk) disable iff (!rst_n_s)
    tick_slow |=> (&ticks));
endmodule

// File: tb/clk_rate_sel_tb.sv
module clk_rate_sel_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] sfr_addr = 8'h00;
  logic       sfr_wr = 1'b0;
  logic       sfr_rd = 1'b0;
  logic [7:0] sfr_wdata = 8'h00;
  logic [7:0] sfr_rdata;
  logic       cpu_tick;
  logic [5:0] per_tick;
  logic [6:0] ticks;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  bit mon_busy = 1'b0;
  bit gap_on = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  clk_rate_sel u_dut (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
    .sfr_rd(sfr_rd), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
    .cpu_tick(cpu_tick), .per_tick(per_tick)
  );

  assign ticks = {per_tick, cpu_tick};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit is_slow(input logic [7:0] c, input int k);
    if (k == 0) return !c[0];
    return !c[0] || c[k];
  endfunction

  task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
    @(negedge clk);
    sfr_wr = 1'b0;
  endtask

  task automatic sfr_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    sfr_addr = a; sfr_rd = 1'b1;
    #1 d = sfr_rdata;
    sfr_rd = 1'b0;
  endtask

  // driver: push expected active config after the settle time, wait for monitor
  task automatic expect_cfg(input logic [7:0] c, input string tag);
    repeat (30) @(negedge clk);
    exp_q.push_back(c);
    tag_q.push_back(tag);
    wait (exp_q.size() == 0 && !mon_busy);
  endtask

  // monitor: counts strobes over a 36-clock window per expected item
  always begin
    logic [7:0] c;
    string tag;
    int cnt[7];
    bit coinc_ok;
    wait (exp_q.size() > 0);
    mon_busy = 1'b1;
    c = exp_q.pop_front();
    tag = tag_q.pop_front();
    foreach (cnt[k]) cnt[k] = 0;
    coinc_ok = 1'b1;
    repeat (36) begin
      @(negedge clk);
      for (int k = 0; k < 7; k++) begin
        if (ticks[k]) cnt[k]++;
        if (ticks[k] && is_slow(c, k) && !(&ticks)) coinc_ok = 1'b0;
      end
    end
    for (int k = 0; k < 7; k++) begin
      int e;
      e = is_slow(c, k) ? 3 : 6;
      chk(cnt[k] == e, $sformatf("%s out%0d cfg=%02h", tag, k, c), cnt[k], e);
    end
    chk(coinc_ok, $sformatf("R9 slow strobes coincide cfg=%02h", c), coinc_ok, 1);
    mon_busy = 1'b0;
  end

  // continuous gap checker: R8 single pulse and legal spacing, R9 across changes
  int last[7];
  int cyc = 0;
  initial foreach (last[k]) last[k] = -1;
  always @(negedge clk) begin
    cyc++;
    if (gap_on) begin
      for (int k = 0; k < 7; k++) begin
        if (ticks[k]) begin
          if (last[k] >= 0)
            chk((cyc - last[k]) == 6 || (cyc - last[k]) == 12,
                $sformatf("R8 R9 gap out%0d", k), cyc - last[k], 12);
          last[k] = cyc;
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    gap_on = 1'b1;

    sfr_read(8'h8F, rv);
    chk(rv == 8'h00, "R1 reset value", rv, 8'h00);
    expect_cfg(8'h00, "R1 reset rates");

    sfr_write(8'h8F, 8'h7E);
    sfr_read(8'h8F, rv);
    chk(rv == 8'h7E, "R2 readback", rv, 8'h7E);
    expect_cfg(8'h7E, "R5 selects ignored");

    sfr_write(8'h8F, 8'h01);
    expect_cfg(8'h01, "R6 R7 all double");

    sfr_write(8'h8F, 8'h55);
    expect_cfg(8'h55, "R7 pattern 55");

    sfr_write(8'h8F, 8'h2B);
    expect_cfg(8'h2B, "R7 pattern 2B");

    sfr_write(8'h8F, 8'hFF);
    sfr_read(8'h8F, rv);
    chk(rv == 8'h7F, "R3 top bit reads zero", rv, 8'h7F);
    expect_cfg(8'h7F, "R7 all held");

    for (int b = 1; b < 7; b++) begin
      logic [7:0] v;
      v = 8'h01 | (8'h01 << b);
      sfr_write(8'h8F, v);
      expect_cfg(v, $sformatf("R7 single hold bit%0d", b));
    end

    sfr_write(8'h8F, 8'h01);
    expect_cfg(8'h01, "R6 back to double");
    sfr_write(8'h8E, 8'h7E);
    sfr_write(8'h90, 8'h00);
    sfr_read(8'h8F, rv);
    chk(rv == 8'h01, "R4 miss write ignored", rv, 8'h01);
    sfr_read(8'h8E, rv);
    chk(rv == 8'h00, "R4 other address reads zero", rv, 8'h00);
    expect_cfg(8'h01, "R4 rates unchanged");

    sfr_write(8'h8F, 8'h00);
    expect_cfg(8'h00, "R5 standard again");

    repeat (5) begin
      sfr_write(8'h8F, 8'h15);
      repeat (3) @(negedge clk);
      sfr_write(8'h8F, 8'h6A);
      repeat (7) @(negedge clk);
    end
    expect_cfg(8'h6A, "R9 after rapid changes");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule